// File: doc/BRIEF.md
# Dual-Mode Pulse-Swallow Frequency Divider

This block divides a local-oscillator clock by a programmable ratio N and hands one single-cycle pulse per N oscillator cycles to a phase comparator. Two oscillator inputs exist: a high-band input and a low-band input. A band bit picks one of them. The high band is always divided through a swallow counter and a dual-modulus 16/17 prescaler that feeds a 12-bit main counter. The low band can either use that same swallow chain or bypass the prescaler, so that the 12-bit counter divides the input cycles directly.

The 16-bit divisor word is read differently in the two modes. In swallow mode the upper 12 bits are the main count P and the lower 4 bits are the swallow count A, so N = 16·P + A. In direct mode the whole word is the ratio. A word outside the legal range of the active mode is clamped to the nearest legal value. The divisor and the swallow/direct choice are sampled only at the edge that ends a period, so a period in progress is never cut short or stretched. Reset is synchronous to the selected oscillator. The band bit drives a plain clock multiplexer, so it may only change while reset is asserted.

Top module: `swallow_divider`

## Requirements
- R1: With `band_hi_i` = 1 the block counts `osc_hi_i` edges in swallow mode. Successive output pulses are N = `div_word_i` cycles apart, with `div_word_i[15:4]` as P and `div_word_i[3:0]` as A.
- R2: With `band_hi_i` = 0 and `lo_swallow_i` = 1 the block counts `osc_lo_i` edges in swallow mode with the same word layout and period as R1.
- R3: With `band_hi_i` = 0 and `lo_swallow_i` = 0 the block counts `osc_lo_i` edges in direct mode, and the period is the whole word value for words from 4 to 4095.
- R4: In swallow mode a word below 272 gives a period of 272 cycles. Every word from 272 to 65535 is used as given.
- R5: In direct mode a word below 4 gives a period of 4 cycles, and a word above 4095 gives a period of 4095 cycles.
- R6: `div_pulse_o` is high for exactly one selected-clock cycle per period. It goes high after the edge that ends the period.
- R7: The divisor word and `lo_swallow_i` are sampled only at the edge that ends a period. Changes made in the middle of a period leave that period's length unchanged and apply to the next period.
- R8: While `rst_i` is high at a selected-clock edge, the output is low after that edge. The first edge with `rst_i` low loads the divisor, and counting that edge as 1, the first pulse is high after edge N+1.
- R9: In swallow mode the prescaler runs 17-cycle counts while the swallow count is not yet used up and 16-cycle counts after that. The swallow count left never reaches the main count left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_hi_i | input | 1 | High-band oscillator clock |
| osc_lo_i | input | 1 | Low-band oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high, sampled on the selected clock |
| band_hi_i | input | 1 | 1 selects the high-band clock and swallow mode; change only during reset |
| lo_swallow_i | input | 1 | With the low band: 1 selects swallow mode, 0 selects direct mode |
| div_word_i | input | 16 | Divisor word: P in [15:4] and A in [3:0] for swallow mode, the full value for direct mode |
| div_pulse_o | output | 1 | One-cycle pulse per divided period |

## Verification
On every cycle, the embedded properties check these points: the pulse never lasts two cycles, reset silences the output, the clamped load always lies within the active mode's range, a 17-cycle prescaler count occurs only while swallow count is left, and the swallow count left stays below the main count left. These properties cannot show the period lengths themselves, the clamping as it appears at the output, or the deferral of a word or mode change to the next boundary. Only the bench shows those, through its cycle-by-cycle reference model and through measured pulse spacings across band switches, mid-period writes and resets taken in the middle of a period.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic {
      DIV_DIRECT  = 1'b0,
      DIV_SWALLOW = 1'b1
   } psd_mode_e;

endpackage

// File: rtl/psd_clk_sel.sv
module psd_clk_sel (
   input  logic sel_hi_i,
   input  logic clk_hi_i,
   input  logic clk_lo_i,
   output logic clk_o
);

   // plain multiplexer: selection may only move while the divider is in reset
   assign clk_o = sel_hi_i ? clk_hi_i : clk_lo_i;

endmodule

// File: rtl/psd_div_limit.sv
module psd_div_limit
   import psd_pkg::*;
#(
   parameter int MAIN_W     = 12,
   parameter int SWAL_W     = 4,
   parameter int DIRECT_MIN = 4,
   localparam int DIV_W     = MAIN_W + SWAL_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  psd_mode_e         mode_i,
   input  logic [DIV_W-1:0]  word_i,
   output logic [MAIN_W-1:0] main_load_o,
   output logic [SWAL_W-1:0] swal_load_o
);

   localparam int PRE_MOD  = 1 << SWAL_W;
   localparam int SWAL_MIN = PRE_MOD * (PRE_MOD + 1);
   localparam int MAIN_MAX = (1 << MAIN_W) - 1;

   logic [DIV_W-1:0] n_swallow;
   logic [DIV_W-1:0] n_direct;

   always_comb begin
      if (word_i < DIV_W'(SWAL_MIN)) n_swallow = DIV_W'(SWAL_MIN);
      else                          n_swallow = word_i;

      if (word_i < DIV_W'(DIRECT_MIN))    n_direct = DIV_W'(DIRECT_MIN);
      else if (word_i > DIV_W'(MAIN_MAX)) n_direct = DIV_W'(MAIN_MAX);
      else                                n_direct = word_i;
   end

   always_comb begin
      if (mode_i == DIV_SWALLOW) begin
         main_load_o = n_swallow[DIV_W-1:SWAL_W];
         swal_load_o = n_swallow[SWAL_W-1:0];
      end else begin
         main_load_o = n_direct[MAIN_W-1:0];
         swal_load_o = '0;
      end
   end

   // R4: swallow loads never fall under the floor
   a_r4_swallow_floor : assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == DIV_SWALLOW) |-> ({main_load_o, swal_load_o} >= DIV_W'(SWAL_MIN)));

   // R5: direct loads stay inside the 12-bit window with no swallow part
   a_r5_direct_window : assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == DIV_DIRECT) |-> ((main_load_o >= MAIN_W'(DIRECT_MIN)) && (swal_load_o == '0)));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
   parameter int SWAL_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [SWAL_W-1:0] swal_load_i,
   input  logic              swallow_en_i,
   output logic              tick_o,
   output logic [SWAL_W-1:0] swal_left_o
);

   localparam int PRE_MOD = 1 << SWAL_W;
   localparam int PRE_W   = SWAL_W + 1;

   logic [PRE_W-1:0]  pre_cnt;
   logic [SWAL_W-1:0] swal_rem;
   logic [PRE_W-1:0]  last_val;
   logic              wrap;

   // modulus PRE_MOD+1 while swallow count is left, PRE_MOD afterwards
   assign last_val = (swal_rem != '0) ? PRE_W'(PRE_MOD) : PRE_W'(PRE_MOD - 1);
   assign wrap     = (pre_cnt == last_val);
   assign tick_o   = swallow_en_i ? wrap : 1'b1;
   assign swal_left_o = swal_rem;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pre_cnt  <= '0;
         swal_rem <= '0;
      end else if (load_i) begin
         pre_cnt  <= '0;
         swal_rem <= swal_load_i;
      end else if (swallow_en_i) begin
         if (wrap) begin
            pre_cnt <= '0;
            if (swal_rem != '0) swal_rem <= swal_rem - 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   // R9: a long count only happens while swallow count is still owed
   a_r9_long_needs_swallow : assert property (@(posedge clk_i) disable iff (rst_i)
      (pre_cnt == PRE_W'(PRE_MOD)) |-> (swal_rem != '0));

   // R9: the prescaler count never runs past the long modulus
   a_r9_pre_bound : assert property (@(posedge clk_i) disable iff (rst_i)
      pre_cnt <= PRE_W'(PRE_MOD));

endmodule

// File: rtl/psd_main_counter.sv
module psd_main_counter #(
   parameter int MAIN_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              step_i,
   input  logic [MAIN_W-1:0] load_i,
   output logic [MAIN_W-1:0] rem_o,
   output logic              idle_o,
   output logic              terminal_o,
   output logic              boundary_o
);

   logic [MAIN_W-1:0] rem;

   assign idle_o     = (rem == '0);
   assign terminal_o = step_i && (rem == MAIN_W'(1));
   assign boundary_o = idle_o || terminal_o;
   assign rem_o      = rem;

   always_ff @(posedge clk_i) begin
      if (rst_i)           rem <= '0;
      else if (boundary_o) rem <= load_i;
      else if (step_i)     rem <= rem - 1'b1;
   end

   // R6: a boundary always leaves a non-empty period behind it
   a_r6_load_nonzero : assert property (@(posedge clk_i) disable iff (rst_i)
      boundary_o |=> (rem != '0));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
   import psd_pkg::*;
#(
   parameter int MAIN_W     = 12,
   parameter int SWAL_W     = 4,
   parameter int DIRECT_MIN = 4,
   localparam int DIV_W     = MAIN_W + SWAL_W
) (
   input  logic             osc_hi_i,
   input  logic             osc_lo_i,
   input  logic             rst_i,
   input  logic             band_hi_i,
   input  logic             lo_swallow_i,
   input  logic [DIV_W-1:0] div_word_i,
   output logic             div_pulse_o
);

   localparam int MAIN_MAX = (1 << MAIN_W) - 1;

   generate
      if (SWAL_W < 1 || MAIN_W <= SWAL_W) begin : g_bad_widths
         $error("swallow_divider: MAIN_W must exceed SWAL_W and SWAL_W must be at least 1");
      end
      if (DIRECT_MIN < 2 || DIRECT_MIN > MAIN_MAX) begin : g_bad_min
         $error("swallow_divider: DIRECT_MIN must lie in 2 .. 2**MAIN_W-1");
      end
   endgenerate

   logic              div_clk;
   psd_mode_e         mode_now;
   psd_mode_e         mode_q;
   logic [MAIN_W-1:0] main_load;
   logic [SWAL_W-1:0] swal_load;
   logic [MAIN_W-1:0] main_rem;
   logic [SWAL_W-1:0] swal_left;
   logic              tick;
   logic              idle;
   logic              terminal;
   logic              boundary;

   assign mode_now = (band_hi_i || lo_swallow_i) ? DIV_SWALLOW : DIV_DIRECT;

   psd_clk_sel u_clk_sel (
      .sel_hi_i (band_hi_i),
      .clk_hi_i (osc_hi_i),
      .clk_lo_i (osc_lo_i),
      .clk_o    (div_clk)
   );

   psd_div_limit #(
      .MAIN_W     (MAIN_W),
      .SWAL_W     (SWAL_W),
      .DIRECT_MIN (DIRECT_MIN)
   ) u_limit (
      .clk_i       (div_clk),
      .rst_i       (rst_i),
      .mode_i      (mode_now),
      .word_i      (div_word_i),
      .main_load_o (main_load),
      .swal_load_o (swal_load)
   );

   psd_prescaler #(
      .SWAL_W (SWAL_W)
   ) u_prescaler (
      .clk_i        (div_clk),
      .rst_i        (rst_i),
      .load_i       (boundary),
      .swal_load_i  (swal_load),
      .swallow_en_i (mode_q == DIV_SWALLOW),
      .tick_o       (tick),
      .swal_left_o  (swal_left)
   );

   psd_main_counter #(
      .MAIN_W (MAIN_W)
   ) u_main (
      .clk_i      (div_clk),
      .rst_i      (rst_i),
      .step_i     (tick),
      .load_i     (main_load),
      .rem_o      (main_rem),
      .idle_o     (idle),
      .terminal_o (terminal),
      .boundary_o (boundary)
   );

   // mode is latched together with the divisor at each period boundary
   always_ff @(posedge div_clk) begin
      if (rst_i) begin
         mode_q      <= DIV_DIRECT;
         div_pulse_o <= 1'b0;
      end else begin
         div_pulse_o <= terminal;
         if (boundary) mode_q <= mode_now;
      end
   end

   // R6: a pulse lasts one cycle only
   a_r6_single_pulse : assert property (@(posedge div_clk) disable iff (rst_i)
      div_pulse_o |=> !div_pulse_o);

   // R8: reset silences the output on the next edge
   a_r8_reset_quiet : assert property (@(posedge div_clk)
      rst_i |=> !div_pulse_o);

   // R9: the swallow count left always fits inside the main count left
   a_r9_swallow_fits : assert property (@(posedge div_clk) disable iff (rst_i)
      ((mode_q == DIV_SWALLOW) && !idle) |-> (main_rem > MAIN_W'(swal_left)));

endmodule

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;

   logic        osc_hi = 1'b0;
   logic        osc_lo = 1'b0;
   logic        rst    = 1'b1;
   logic        band   = 1'b1;
   logic        sub    = 1'b0;
   logic [15:0] word   = 16'd100;
   logic        div_o;

   always #2.5 osc_hi = ~osc_hi;   // 200 MHz high-band clock
   always #3.5 osc_lo = ~osc_lo;   // low-band clock

   swallow_divider u0 (
      .osc_hi_i     (osc_hi),
      .osc_lo_i     (osc_lo),
      .rst_i        (rst),
      .band_hi_i    (band),
      .lo_swallow_i (sub),
      .div_word_i   (word),
      .div_pulse_o  (div_o)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit cmp_on = 1'b0;

   // behavioural reference: cycle count within the period, expected N
   bit m_idle = 1'b1;
   bit m_out  = 1'b0;
   int m_cnt  = 0;
   int m_n    = 0;

   function automatic int exp_div(int w, bit swallow);
      if (swallow) return (w < 272) ? 272 : w;
      if (w < 4) return 4;
      if (w > 4095) return 4095;
      return w;
   endfunction

   task automatic model_step();
      if (rst) begin
         m_idle = 1'b1; m_out = 1'b0; m_cnt = 0;
      end else if (m_idle) begin
         m_idle = 1'b0; m_out = 1'b0; m_cnt = 0;
         m_n = exp_div(int'(word), band || sub);
      end else begin
         m_cnt++;
         if (m_cnt == m_n) begin
            m_out = 1'b1; m_cnt = 0;
            m_n = exp_div(int'(word), band || sub);
         end else begin
            m_out = 1'b0;
         end
      end
   endtask

   always @(posedge osc_hi) if (band)  model_step();
   always @(posedge osc_lo) if (!band) model_step();

   task automatic cmp_now();
      checks++;
      if (div_o !== m_out) begin
         errors++;
         $display("FAIL R6 %s per-cycle compare: got %0b expected %0b",
                  band ? "R1" : (sub ? "R2" : "R3"), div_o, m_out);
      end
   endtask

   always @(negedge osc_hi) if (band && cmp_on)  cmp_now();
   always @(negedge osc_lo) if (!band && cmp_on) cmp_now();

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      if (band) @(negedge osc_hi);
      else      @(negedge osc_lo);
   endtask

   // count sampled cycles until the output is seen high
   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         cyc();
         n++;
      end while (div_o !== 1'b1 && n < 70000);
   endtask

   task automatic switch_band(bit b);
      rst = 1'b1;
      repeat (3) cyc();
      band = b;
      repeat (3) cyc();
   endtask

   initial begin
      int n;
      repeat (2) cyc();
      cmp_on = 1'b1;
      repeat (3) cyc();
      chk("R8 output low in reset", int'(div_o), 0);

      // high band, word below the swallow floor
      rst = 1'b0;
      wait_pulse(n);
      chk("R8 first pulse after release (R4 N=272)", n, 273);
      wait_pulse(n);
      chk("R4 swallow floor period", n, 272);
      cyc();
      chk("R6 pulse one cycle wide", int'(div_o), 0);

      // R1: P=62 A=8
      word = 16'h03E8;
      wait_pulse(n);
      chk("R7 period in flight keeps 272", n, 271);
      wait_pulse(n);
      chk("R1 swallow period 1000", n, 1000);

      // R9: A=15, smallest P that fits
      word = 16'h011F;
      wait_pulse(n);
      wait_pulse(n);
      chk("R9 swallow period 287 with A=15", n, 287);

      // R7: mid-period word change
      word = 16'd300;
      wait_pulse(n);
      wait_pulse(n);
      chk("R1 swallow period 300", n, 300);
      repeat (100) cyc();
      word = 16'd500;
      wait_pulse(n);
      chk("R7 mid-period write deferred", n, 200);
      wait_pulse(n);
      chk("R7 new word applies next period", n, 500);

      // low band, swallow mode
      switch_band(1'b0);
      sub  = 1'b1;
      word = 16'h0123;
      rst  = 1'b0;
      wait_pulse(n);
      chk("R8 first pulse on low band", n, 292);
      wait_pulse(n);
      chk("R2 low-band swallow period 291", n, 291);

      // R7: mode bit changed mid-period
      repeat (50) cyc();
      sub  = 1'b0;
      word = 16'd100;
      wait_pulse(n);
      chk("R7 mode change deferred", n, 241);
      wait_pulse(n);
      chk("R3 direct period 100", n, 100);

      // R5 clamps
      word = 16'd5000;
      wait_pulse(n);
      wait_pulse(n);
      chk("R5 direct ceiling 4095", n, 4095);
      word = 16'd2;
      wait_pulse(n);
      wait_pulse(n);
      chk("R5 direct floor 4", n, 4);
      cyc();
      chk("R6 low after short-period pulse", int'(div_o), 0);
      word = 16'd4;
      wait_pulse(n);
      wait_pulse(n);
      chk("R3 direct period 4", n, 4);
      word = 16'd7;
      wait_pulse(n);
      wait_pulse(n);
      chk("R3 direct period 7", n, 7);

      // R4 on the low band
      sub  = 1'b1;
      word = 16'd10;
      wait_pulse(n);
      wait_pulse(n);
      chk("R4 low-band swallow floor", n, 272);

      // R8: reset in the middle of a period
      sub  = 1'b0;
      word = 16'd100;
      wait_pulse(n);
      repeat (30) cyc();
      rst = 1'b1;
      repeat (3) begin
         cyc();
         chk("R8 output held low", int'(div_o), 0);
      end
      rst = 1'b0;
      wait_pulse(n);
      chk("R8 restart after mid-period reset", n, 101);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run finished got 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule